// File: doc/BRIEF.md
# Double-Data-Rate Input Capture with Half-Rate Word Output

This block receives one serial data bit that changes on both edges of a strobe clock. It takes one sample on the rising edge and one on the falling edge. The falling-edge sample is then moved onto the rising edge, so both samples leave the capture stage as one aligned bit pair. The pair then passes through up to `RS_DEPTH` resynchronization register levels clocked by the resynchronization clock. Each level can be skipped by its own static configuration bit.

The final stage runs at half the resynchronization rate and packs two successive pairs into a four-bit word for the fabric. A run-time select picks which of two streams reaches the output. The full-rate stream delivers one pair on every resynchronization cycle. The half-rate stream delivers one word on every second cycle. All clocks are treated as ideal and phase-related. In simulation the capture clock and the resynchronization clock may share one source.

The output is a valid-only stream. The sink cannot apply back-pressure: a beat is present for exactly the cycle in which `out_valid` is high and is not held for the sink. Control inputs are plain level signals. `cfg_bypass` may change only while `rst` is high. `out_sel` may change on any cycle.

Top module: `ddr_rx_halfrate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is sampled high, `out_valid` is 0 and `out_data` is 0 in both output modes.
- R2: The sample taken on a rising capture edge appears in bit 0 of the full-rate pair. The sample taken on the falling edge that follows appears in bit 1 of the same pair. Bits 3:2 of `out_data` are 0 in full-rate mode.
- R3: The full-rate pair whose rising sample was taken at capture edge n is on `out_data` after resync edge n+1+L. L is the number of resync levels whose `cfg_bypass` bit is 0.
- R4: Each `cfg_bypass` bit removes exactly one cycle of latency, whichever level it belongs to, and does not alter the data.
- R5: A half-rate word puts the older pair in bits 1:0 and the newer pair in bits 3:2, as {fall1, rise1, fall0, rise0}, so rise0 is bit 0.
- R6: In half-rate mode, `out_valid` is high after the second resync edge following reset release, and on every second edge after that. A new reset restarts this phase.
- R7: In full-rate mode (`out_sel`=1), `out_valid` is high on every cycle from the first edge after reset release onward.
- R8: Changing `out_sel` takes effect on the output within the same cycle. It does not disturb the pairing or the phase of the half-rate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Strobe clock; data is sampled on both of its edges |
| rs_clk | input | 1 | Resynchronization clock for the resync levels and the half-rate stage |
| rst | input | 1 | Synchronous active-high reset; also sets the half-rate phase |
| din | input | 1 | Double-data-rate serial input bit |
| cfg_bypass | input | max(RS_DEPTH,1) | Static skip bit per resync level (bit i skips level i) |
| out_sel | input | 1 | 1 = full-rate pair on the output, 0 = half-rate word |
| out_data | output | 4 | Pair in bits 1:0 (full-rate mode) or four-bit word (half-rate mode) |
| out_valid | output | 1 | High for each cycle that carries a beat |

## Verification
The checker watches four behaviours on every cycle. It checks that reset leaves the output quiet. It checks that a rising sample reaches the full-rate output two cycles later when every level is skipped. It checks that each newly produced word is made of the two pairs that came out of the resync chain on the two cycles before it. It checks that half-rate valids never occur on back-to-back cycles and that full-rate valids never drop. With no levels skipped, it also matches the chain output against the capture pair delayed by three cycles. Only the bench scenarios can show the latency for each mix of skipped levels, the word order for known data patterns, the restart of the half-rate phase after a reset, and correct output while `out_sel` toggles mid-stream.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } bitpair_t;

  localparam int unsigned WORD_W = 4;
endpackage

// File: rtl/ddr_cap_stage.sv
module ddr_cap_stage
  import ddr_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     din,
  output bitpair_t pair_o
);
  logic rise_smp, rise_algn, fall_smp, fall_algn;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_smp  <= 1'b0;
      rise_algn <= 1'b0;
      fall_algn <= 1'b0;
    end else begin
      rise_smp  <= din;
      rise_algn <= rise_smp;
      fall_algn <= fall_smp;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fall_smp <= 1'b0;
    else     fall_smp <= din;
  end

  assign pair_o = '{fall: fall_algn, rise: rise_algn};
endmodule

// File: rtl/ddr_resync_chain.sv
module ddr_resync_chain
  import ddr_rx_pkg::*;
#(
  parameter int unsigned RS_DEPTH = 3,
  localparam int unsigned BW = (RS_DEPTH > 0) ? RS_DEPTH : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] skip,
  input  bitpair_t      pair_i,
  output bitpair_t      pair_o
);
  bitpair_t lvl [0:RS_DEPTH];

  assign lvl[0] = pair_i;

  for (genvar i = 0; i < RS_DEPTH; i++) begin : g_lvl
    bitpair_t q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= lvl[i];
    end
    assign lvl[i+1] = skip[i] ? lvl[i] : q;
  end

  if (RS_DEPTH == 0) begin : g_nolvl
    logic unused_skip;
    assign unused_skip = ^skip;
  end

  assign pair_o = lvl[RS_DEPTH];
endmodule

// File: rtl/ddr_halfrate_pack.sv
module ddr_halfrate_pack
  import ddr_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bitpair_t          pair_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              run_o
);
  logic     phase;
  bitpair_t older;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b0;
      older      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      run_o      <= 1'b0;
    end else begin
      phase      <= ~phase;
      run_o      <= 1'b1;
      word_vld_o <= phase;
      if (!phase) older  <= pair_i;
      else        word_o <= {pair_i, older};
    end
  end
endmodule

// File: rtl/ddr_rx_halfrate.sv
module ddr_rx_halfrate
  import ddr_rx_pkg::*;
#(
  parameter int unsigned RS_DEPTH = 3
) (
  input  logic                                    cap_clk,
  input  logic                                    rs_clk,
  input  logic                                    rst,
  input  logic                                    din,
  input  logic [((RS_DEPTH > 0) ? RS_DEPTH : 1)-1:0] cfg_bypass,
  input  logic                                    out_sel,
  output logic [3:0]                              out_data,
  output logic                                    out_valid
);
  bitpair_t    cap_pair, rs_pair;
  logic [3:0]  hr_word;
  logic        hr_vld, hr_run;

  ddr_cap_stage u_cap (
    .clk(cap_clk), .rst(rst), .din(din), .pair_o(cap_pair)
  );

  ddr_resync_chain #(.RS_DEPTH(RS_DEPTH)) u_chain (
    .clk(rs_clk), .rst(rst), .skip(cfg_bypass),
    .pair_i(cap_pair), .pair_o(rs_pair)
  );

  ddr_halfrate_pack u_pack (
    .clk(rs_clk), .rst(rst), .pair_i(rs_pair),
    .word_o(hr_word), .word_vld_o(hr_vld), .run_o(hr_run)
  );

  always_comb begin
    if (out_sel) begin
      out_data  = {2'b00, rs_pair};
      out_valid = hr_run;
    end else begin
      out_data  = hr_word;
      out_valid = hr_vld;
    end
  end
endmodule

// File: rtl/ddr_rx_halfrate_chk.sv
module ddr_rx_halfrate_chk
  import ddr_rx_pkg::*;
#(
  parameter int unsigned RS_DEPTH = 3,
  localparam int unsigned BW = (RS_DEPTH > 0) ? RS_DEPTH : 1
) (
  input logic          rs_clk,
  input logic          rst,
  input logic          din,
  input logic [BW-1:0] cfg_bypass,
  input logic          out_sel,
  input logic [3:0]    out_data,
  input logic          out_valid,
  input bitpair_t      cap_pair,
  input bitpair_t      rs_pair,
  input logic [3:0]    hr_word,
  input logic          hr_vld
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge rs_clk)
    rst |=> (!out_valid && out_data == 4'h0));

  // R2
  a_r2_rise_path: assert property (@(posedge rs_clk) disable iff (rst)
    (out_sel && cfg_bypass == '1 && !$past(rst) && !$past(rst, 2))
      |-> out_data[0] == $past(din, 2));

  // R3
  if (RS_DEPTH == 3) begin : g_depth3
    a_r3_chain_depth: assert property (@(posedge rs_clk) disable iff (rst)
      (cfg_bypass == '0) |-> rs_pair == $past(cap_pair, 3));
  end

  // R5
  a_r5_word_order: assert property (@(posedge rs_clk) disable iff (rst)
    $rose(hr_vld) |-> hr_word == {$past(rs_pair), $past(rs_pair, 2)});

  // R6
  a_r6_valid_alternates: assert property (@(posedge rs_clk) disable iff (rst)
    (!out_sel && out_valid) |=> (out_sel || !out_valid));

  // R7
  a_r7_full_valid: assert property (@(posedge rs_clk) disable iff (rst)
    (out_sel && !$past(rst)) |-> out_valid);
endmodule

bind ddr_rx_halfrate ddr_rx_halfrate_chk #(.RS_DEPTH(RS_DEPTH)) u_chk (
  .rs_clk(rs_clk), .rst(rst), .din(din), .cfg_bypass(cfg_bypass),
  .out_sel(out_sel), .out_data(out_data), .out_valid(out_valid),
  .cap_pair(cap_pair), .rs_pair(rs_pair), .hr_word(hr_word), .hr_vld(hr_vld)
);

// File: tb/ddr_rx_halfrate_bench.sv
`timescale 1ns/1ps
module ddr_rx_halfrate_bench;
  localparam int DEPTH = 3;
  localparam int NCYC  = 16;
  localparam int NCASE = 12;
  // entry = {latency[1:0], mode[1:0] (0 half, 1 full, 2 toggling), bypass[2:0]}
  localparam logic [6:0] CASES [NCASE] = '{
    {2'd3, 2'd1, 3'b000}, {2'd2, 2'd1, 3'b001}, {2'd2, 2'd1, 3'b010},
    {2'd2, 2'd1, 3'b100}, {2'd1, 2'd1, 3'b011}, {2'd1, 2'd1, 3'b110},
    {2'd0, 2'd1, 3'b111}, {2'd3, 2'd0, 3'b000}, {2'd1, 2'd0, 3'b101},
    {2'd0, 2'd0, 3'b111}, {2'd2, 2'd2, 3'b010}, {2'd0, 2'd2, 3'b111}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [DEPTH-1:0] cfg_bypass = '0;
  logic out_sel = 1'b1;
  logic [3:0] out_data;
  logic out_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic r_hist [NCYC];
  logic f_hist [NCYC];

  always #4 clk = ~clk;

  ddr_rx_halfrate #(.RS_DEPTH(DEPTH)) u_ddr_rx_halfrate (
    .cap_clk(clk), .rs_clk(clk), .rst(rst), .din(din),
    .cfg_bypass(cfg_bypass), .out_sel(out_sel),
    .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic rb(input int i);
    return (i < 0) ? 1'b0 : r_hist[i];
  endfunction
  function automatic logic fb(input int i);
    return (i < 0) ? 1'b0 : f_hist[i];
  endfunction

  task automatic do_reset(input logic sel);
    @(posedge clk); #1 rst = 1'b1; din = 1'b0; out_sel = sel;
    repeat (2) @(posedge clk);
    #2 check("R1 reset quiet", {out_valid, out_data}, 5'h00);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic run_case(input int c);
    logic [2:0] byp;
    int mode, lat;
    logic sel;
    byp  = CASES[c][2:0];
    mode = int'(CASES[c][4:3]);
    lat  = int'(CASES[c][6:5]);
    for (int n = 0; n < NCYC; n++) begin
      r_hist[n] = logic'(((n * 37 + c * 11) >> 2) ^ n);
      f_hist[n] = logic'(((n * 13 + c * 5) >> 1) ^ (n >> 2));
    end
    @(posedge clk); #1 rst = 1'b1; cfg_bypass = byp;
    do_reset(mode != 0);
    for (int n = 0; n < NCYC; n++) begin
      @(negedge clk); #1 din = r_hist[n];
      @(posedge clk); #1 din = f_hist[n];
      #1;
      sel = out_sel;
      if (sel) begin
        check(mode == 2 ? "R8 select full" : (byp == 3'b000 || byp == 3'b111) ? "R3 full latency" : "R4 skip level",
              {out_valid, out_data}, {1'b1, 2'b00, fb(n-1-lat), rb(n-1-lat)});
      end else if (n % 2 == 1) begin
        check(mode == 2 ? "R8 select half" : "R5 word order",
              {out_valid, out_data},
              {1'b1, fb(n-2-lat), rb(n-2-lat), fb(n-3-lat), rb(n-3-lat)});
      end else begin
        check("R6 idle phase", {4'h0, out_valid}, 5'h00);
      end
      if (mode == 2) out_sel = ~out_sel;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < NCASE; c++) run_case(c);
    // R7: full-rate valid on the first edge after release
    cfg_bypass = '0;
    do_reset(1'b1);
    @(posedge clk); #2 check("R7 first valid", {4'h0, out_valid}, 5'h01);
    // R2: single isolated pulses with all levels skipped
    cfg_bypass = '1;
    do_reset(1'b1);
    @(negedge clk); #1 din = 1'b1;
    @(posedge clk); #1 din = 1'b0;
    @(posedge clk); #2 check("R2 rise to bit0", {1'b0, out_data}, 5'h01);
    @(negedge clk); #1 din = 1'b0;
    @(posedge clk); #1 din = 1'b1;
    @(negedge clk); #1 din = 1'b0;
    @(posedge clk); #2 check("R2 fall to bit1", {1'b0, out_data}, 5'h02);
    // R6: reset mid-stream restarts the half-rate phase
    do_reset(1'b0);
    @(posedge clk); #2 check("R6 no valid at first edge", {4'h0, out_valid}, 5'h00);
    @(posedge clk); #2 check("R6 valid at second edge", {4'h0, out_valid}, 5'h01);
    @(posedge clk); #2 check("R6 gap after valid", {4'h0, out_valid}, 5'h00);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule